// File: doc/BRIEF.md
# Auto-Reload Timer/Counter with Shadow Reload Registers

This block is a 16-bit up-counter that can act either as a timer or as an event counter. As a timer it advances on the system clock, either on every cycle or once every twelve cycles through a divide-by-twelve prescaler. As an event counter it advances once on each falling edge of an external pin, after that pin has passed through a two-flop synchronizer. When the count passes 0xFFFF, an interrupt request flag is raised, and in the same cycle the count is reloaded from a pair of hidden reload bytes.

A byte-wide register bus reaches the two count bytes and the flag. Each count byte has a hidden reload byte that sits at the same bus address. While the timer is stopped, a write to a count byte sets both the live byte and its reload byte. While the timer is running, the write sets only the reload byte, so software can change the next period without disturbing the period in progress. A read always returns the live count. Run, mode and prescale selection arrive as plain input bits.

Top module: `reload_timer16`

## Requirements
- R1: While `run_en` is 0, a bus write to address 0 (low byte) or address 1 (high byte) sets that live count byte and its reload byte to the written value.
- R2: While `run_en` is 1, a bus write to address 0 or 1 sets only the reload byte. The live count continues counting as if the write had not happened.
- R3: A bus read of address 0 or 1 returns the live count byte, never the reload byte. `bus_rdata` is registered and shows the value present at the clock edge after the address was presented. A read of address 2 returns the flag in bit 0.
- R4: In timing mode (`ext_mode`=0) with `fast_mode`=1, the count advances by one on every clock while running.
- R5: In timing mode with `fast_mode`=0, the count advances once every 12 clocks. The prescaler restarts from zero whenever `run_en` is 0, so the first advance comes 12 clocks after the run starts.
- R6: In counting mode (`ext_mode`=1), the count advances by exactly one for each falling edge of `ext_pin`, after a two-flop synchronizer, whatever `fast_mode` is set to. Rising edges do not advance the count.
- R7: When an advance occurs at count 0xFFFF, the flag (`irq`) is set and the reload pair is copied into the live count in that same cycle. With reload value R, the overflow period is 65536−R advances.
- R8: The flag stays set until a bus write to address 2 with bit 0 equal to 0. If an overflow and a clear happen in the same cycle, the flag stays set.
- R9: While `run_en` is 0, the count changes only through bus writes, and no overflow or reload occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 = counter running |
| ext_mode | input | 1 | 0 = timing mode, 1 = count external pin falling edges |
| fast_mode | input | 1 | 1 = advance every clock, 0 = every 12 clocks (timing mode) |
| ext_pin | input | 1 | Asynchronous external pulse input |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 flag |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered bus read data |
| irq | output | 1 | Interrupt request flag |

## Verification
The hardest case to produce from the ports is a flag clear that lands in the same clock as an overflow. The stimulus sets up for it while the timer is stopped: it loads 0xFFFF and leaves the flag set from an earlier overflow. It then raises `run_en` in fast mode on the same edge as the clear write, so the overflow and the clear meet in one clock. A second case that is hard to observe is the write made while running. Its effect shows up only one period later, so the bench measures two consecutive overflow periods: the first period follows the old reload value and the second follows the new one.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int FLAG_ADR = 2;
endpackage

// File: rtl/rt_pin_sync.sv
module rt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic fall_pulse
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[SH_W-2:0], pin_async};
  end

  // Falling edge of the synchronized pin: older sample high, newer low.
  assign fall_pulse = sh_q[SH_W-1] & ~sh_q[SH_W-2];

  // R6: one detected edge is never followed at once by another
  a_r6_single_edge: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run)     pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);

  // R5: the prescaler restarts while stopped
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    !run |=> pre_q == '0);
  // R5: a tick is followed by a fresh division cycle
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick || (DIV == 1));
endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              adv,
  input  logic [CNT_W/BYTE_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              flag_q
);
  localparam int NB = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ovf;

  assign ovf = run && adv && (cnt_q == CMAX);

  always_comb begin
    cnt_nxt = cnt_q;
    if (run) begin
      if (adv) cnt_nxt = ovf ? rld_q : cnt_q + 1'b1;
    end else begin
      for (int b = 0; b < NB; b++)
        if (wr_sel[b]) cnt_nxt[b*BYTE_W +: BYTE_W] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // Reload bytes take every write, running or not.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            rld_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_sel[g]) rld_q[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (ovf)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  // R9: a stopped counter with no write holds its value
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && wr_sel == '0) |=> $stable(cnt_q));
  // R9: no flag can rise while stopped
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !run |=> !$rose(flag_q));
  // R2: a running write without an advance leaves the live count alone
  a_r2_live_kept: assert property (@(posedge clk) disable iff (rst)
    (run && !adv && wr_sel != '0) |=> $stable(cnt_q));
  // R7: overflow reloads and raises the flag in one step
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    (run && adv && cnt_q == CMAX) |=> (cnt_q == $past(rld_q)) && flag_q);
  // R8: overflow wins over a simultaneous clear
  a_r8_ovf_wins: assert property (@(posedge clk) disable iff (rst)
    (ovf && flag_clr) |=> flag_q);
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESCALE  = 12,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              ext_mode,
  input  logic              fast_mode,
  input  logic              ext_pin,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int NB = CNT_W / BYTE_W;

  logic              pre_tick;
  logic              pin_fall;
  logic              adv;
  logic [NB-1:0]     wr_sel;
  logic              flag_clr;
  logic [CNT_W-1:0]  cnt;
  logic              flag;

  rt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(run_en && !ext_mode), .tick(pre_tick)
  );

  rt_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .pin_async(ext_pin), .fall_pulse(pin_fall)
  );

  always_comb begin
    if (ext_mode)       adv = pin_fall;
    else if (fast_mode) adv = 1'b1;
    else                adv = pre_tick;
  end

  for (genvar g = 0; g < NB; g++) begin : g_sel
    assign wr_sel[g] = bus_wr && (bus_addr == ADDR_W'(g));
  end

  assign flag_clr = bus_wr && (bus_addr == ADDR_W'(FLAG_ADR)) && !bus_wdata[0];

  rt_count_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst), .run(run_en), .adv(adv), .wr_sel(wr_sel),
    .wr_data(bus_wdata), .flag_clr(flag_clr), .cnt_q(cnt), .flag_q(flag)
  );

  logic [BYTE_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NB; b++)
      if (bus_addr == ADDR_W'(b)) rd_nxt = cnt[b*BYTE_W +: BYTE_W];
    if (bus_addr == ADDR_W'(FLAG_ADR)) rd_nxt = {{(BYTE_W-1){1'b0}}, flag};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

  assign irq = flag;

  // R3: read data follows the live low byte of the previous cycle
  a_r3_live_read: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |=> bus_rdata == $past(cnt[BYTE_W-1:0]));
  // R4: fast timing mode advances every cycle below the top value
  a_r4_fast_step: assert property (@(posedge clk) disable iff (rst)
    (run_en && !ext_mode && fast_mode && cnt != '1) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/test_reload_timer16.sv
module test_reload_timer16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, ext_mode = 1'b0, fast_mode = 1'b1, ext_pin = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reload_timer16 i_reload_timer16 (
    .clk(clk), .rst(rst), .run_en(run_en), .ext_mode(ext_mode),
    .fast_mode(fast_mode), .ext_pin(ext_pin), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    tick();
    v = bus_rdata;
  endtask

  task automatic rd16(output int v);
    int lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic load16(input int v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  // Expected overflow period in clocks from reload value and prescale choice.
  function automatic int period(int rl, bit fast);
    return (65536 - rl) * (fast ? 1 : 12);
  endfunction

  task automatic measure(output int n);
    n = 0;
    while (!irq && n < 5000) begin tick(); n++; end
  endtask

  initial begin
    int v, n, rl;
    void'($urandom(32'd1234));
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R9 reset irq", irq, 0);
    rd16(v); check("R3 reset count", v, 0);

    // R1 stopped write sets live count; R3 read shows it
    load16(16'h1234);
    rd16(v); check("R1 stopped write live", v, 16'h1234);
    // R2: running write to high byte leaves live count
    run_en = 1'b1; fast_mode = 1'b1;
    wr(2'd1, 8'hAB);
    run_en = 1'b0;
    rd16(v); check("R2 running write live untouched R3", v, 16'h1235);

    // R9 stopped: no advance, no overflow
    load16(16'hFFFF);
    for (int i = 0; i < 30; i++) tick();
    rd16(v); check("R9 stopped hold", v, 16'hFFFF);
    check("R9 stopped no flag", irq, 0);

    // R4/R7 random reload periods in fast mode, R5 in slow mode
    for (int k = 0; k < 8; k++) begin
      bit fm;
      fm = (k < 6);
      rl = (k == 0) ? 16'hFFFF : (16'hFF00 | ($urandom() & 8'hFF));
      if (!fm) rl = 16'hFFF0 | ($urandom() & 4'hF);
      run_en = 1'b0; fast_mode = fm;
      load16(rl);
      wr(2'd2, 8'h00);
      run_en = 1'b1;
      measure(n);
      check(fm ? "R4 R7 fast period" : "R5 R7 slow period", n, period(rl, fm));
      run_en = 1'b0;
      rd16(v); check("R7 reloaded count", v, rl);
    end

    // R2 running write changes only the next period
    fast_mode = 1'b1;
    load16(16'hFFE0);
    wr(2'd2, 8'h00);
    run_en = 1'b1;
    wr(2'd0, 8'hF8);
    measure(n);
    check("R2 first period uses old reload", n + 1, 32);
    wr(2'd2, 8'h00);
    measure(n);
    check("R2 second period uses new reload", n + 1, 8);
    run_en = 1'b0;
    check("R8 flag held after stop", irq, 1);
    rd(2'd2, v); check("R3 flag read", v, 1);

    // R8 overflow and clear in the same cycle: overflow wins
    load16(16'hFFFF);
    run_en = 1'b1; fast_mode = 1'b1;
    wr(2'd2, 8'h00);
    run_en = 1'b0;
    check("R8 overflow beats clear", irq, 1);
    wr(2'd2, 8'h01);
    check("R8 write of 1 keeps flag", irq, 1);
    wr(2'd2, 8'h00);
    check("R8 clear", irq, 0);

    // R6 external falling edges, slow prescale ignored
    load16(16'hFFFE);
    ext_mode = 1'b1; fast_mode = 1'b0; run_en = 1'b1;
    for (int i = 0; i < 6; i++) tick();
    ext_pin = 1'b0; for (int i = 0; i < 6; i++) tick();
    ext_pin = 1'b1; for (int i = 0; i < 6; i++) tick();
    run_en = 1'b0;
    rd16(v); check("R6 one edge one count", v, 16'hFFFF);
    check("R6 no flag yet", irq, 0);
    run_en = 1'b1;
    ext_pin = 1'b0; for (int i = 0; i < 6; i++) tick();
    run_en = 1'b0;
    check("R6 R7 edge overflow flag", irq, 1);
    rd16(v); check("R6 R7 reload after edge overflow", v, 16'hFFFE);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule